// File: doc/BRIEF.md
# Three-Source Minterm Block Transfer Engine

This block moves a rectangle of 16-bit words through memory and combines up to three input streams bitwise on the way. Channel A carries a mask or source, channel B a second source, and channel C reads back the destination so that the result can be merged with what is already there. The result stream goes out on channel D. Each output bit is looked up in an 8-entry truth table, the minterm code, indexed by the matching A, B and C bits. This lets one engine perform plain copies, masked overlays and XOR blits.

Software fills a small register file with the following values: a start address and a row modulo per channel, the rectangle width in words and its height in rows, the three source enables and the minterm code. A write to the start register launches the transfer. The engine then walks the rectangle in raster order on a single word-wide request/grant memory port, makes one access per granted cycle, and reports progress through a busy level and a one-cycle done pulse.

Top module: `blit_engine`

## Requirements
- R1: Each output bit i equals bit k of the minterm code, where k = 4*A[i] + 2*B[i] + C[i] (A is the most significant index bit).
- R2: A source whose enable bit is clear (enable register bit 0 = A, bit 1 = B, bit 2 = C) issues no memory read and feeds all zeros into the truth table.
- R3: For each word, the enabled reads are issued in the order A, B, C, followed by the D write (mem_we=1). Exactly one access completes per cycle in which mem_req and mem_gnt are both high. While a request waits for its grant, mem_addr and mem_we hold still.
- R4: Words are visited row by row, left to right. Within a row each channel's address steps by +1. After a row's last word, a channel's next address is that word's address + 1 + the channel's modulo.
- R5: A width or height register value of 0 acts as 1. The transfer makes exactly width*height D writes.
- R6: Writing the start register (index 12) while idle raises busy in the next cycle. While busy, writes to any register, including the start register, are ignored.
- R7: In the cycle after the final D write is granted, done is high for exactly one cycle and busy is low.
- R8: After reset, busy, done and mem_req are low, and mem_req is never high while busy is low.
- R9: Minterm 0xF0 copies A, 0xCA uses A to select B over C, and 0x5A yields A XOR C.

Register indices on cfg_idx: 0..3 channel A..D start address, 4..7 channel A..D modulo (two's complement), 8 width, 9 height, 10 minterm (low 8 bits), 11 enables (low 3 bits), 12 start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | ADDR_W | Register write data |
| busy | output | 1 | High while a transfer runs |
| done | output | 1 | One-cycle pulse when the transfer ends |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write (channel D), 0 = read |
| mem_addr | output | ADDR_W | Word address of the access |
| mem_wdata | output | DATA_W | Write data for channel D |
| mem_gnt | input | 1 | Access completes at this clock edge |
| mem_rdata | input | DATA_W | Read data, valid in the granted cycle |

## Verification
busy is due one cycle after the start write. The bench samples it on the falling edge right after that write's rising edge. Read data is captured at the granting edge, and the D write that uses it appears on the port at the next cycle's request, so results are judged from the logged grant sequence and the final memory image rather than from fixed delays. done and the fall of busy are due one cycle after the last D grant. The bench counts done pulses on falling edges and requires exactly one, with busy already low. Grants are withheld at random, so every access may stretch over several cycles without shifting the expected order.

// File: rtl/blit_pkg.sv
package blit_pkg;

  localparam int unsigned NUM_CH = 4;
  localparam int unsigned CH_A   = 0;
  localparam int unsigned CH_B   = 1;
  localparam int unsigned CH_C   = 2;
  localparam int unsigned CH_D   = 3;

  // register indices on the configuration port
  localparam logic [3:0] RG_BASE0   = 4'd0;
  localparam logic [3:0] RG_MOD0    = 4'd4;
  localparam logic [3:0] RG_WIDTH   = 4'd8;
  localparam logic [3:0] RG_HEIGHT  = 4'd9;
  localparam logic [3:0] RG_MINTERM = 4'd10;
  localparam logic [3:0] RG_ENABLE  = 4'd11;
  localparam logic [3:0] RG_START   = 4'd12;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RDA  = 3'd1,
    ST_RDB  = 3'd2,
    ST_RDC  = 3'd3,
    ST_WRD  = 3'd4
  } blit_state_t;

  // phase following cur for the given source enables
  function automatic blit_state_t next_phase(blit_state_t cur, logic [2:0] en);
    blit_state_t nxt;
    case (cur)
      ST_RDA:  nxt = en[1] ? ST_RDB : (en[2] ? ST_RDC : ST_WRD);
      ST_RDB:  nxt = en[2] ? ST_RDC : ST_WRD;
      ST_RDC:  nxt = ST_WRD;
      default: nxt = en[0] ? ST_RDA : (en[1] ? ST_RDB : (en[2] ? ST_RDC : ST_WRD));
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [3:0]                      cfg_idx,
  input  logic [ADDR_W-1:0]               cfg_wdata,
  input  logic                            lock,
  output logic [NUM_CH-1:0][ADDR_W-1:0]   base_o,
  output logic [NUM_CH-1:0][ADDR_W-1:0]   mod_o,
  output logic [CNT_W-1:0]                width_o,
  output logic [CNT_W-1:0]                height_o,
  output logic [7:0]                      minterm_o,
  output logic [2:0]                      en_o,
  output logic                            start_o
);

  logic                           wr_ok;
  logic [NUM_CH-1:0][ADDR_W-1:0]  base_q;
  logic [NUM_CH-1:0][ADDR_W-1:0]  mod_q;
  logic [CNT_W-1:0]               width_q;
  logic [CNT_W-1:0]               height_q;
  logic [7:0]                     minterm_q;
  logic [2:0]                     en_q;

  assign wr_ok = cfg_we && !lock;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic base_en;
    logic mod_en;
    assign base_en = wr_ok && (cfg_idx == RG_BASE0 + 4'(g));
    assign mod_en  = wr_ok && (cfg_idx == RG_MOD0 + 4'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        mod_q[g]  <= '0;
      end else begin
        if (base_en) base_q[g] <= cfg_wdata;
        if (mod_en)  mod_q[g]  <= cfg_wdata;
      end
    end
  end

  logic width_en, height_en, minterm_en, en_en;
  assign width_en   = wr_ok && (cfg_idx == RG_WIDTH);
  assign height_en  = wr_ok && (cfg_idx == RG_HEIGHT);
  assign minterm_en = wr_ok && (cfg_idx == RG_MINTERM);
  assign en_en      = wr_ok && (cfg_idx == RG_ENABLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q   <= '0;
      height_q  <= '0;
      minterm_q <= '0;
      en_q      <= '0;
    end else begin
      if (width_en)   width_q   <= cfg_wdata[CNT_W-1:0];
      if (height_en)  height_q  <= cfg_wdata[CNT_W-1:0];
      if (minterm_en) minterm_q <= cfg_wdata[7:0];
      if (en_en)      en_q      <= cfg_wdata[2:0];
    end
  end

  assign base_o    = base_q;
  assign mod_o     = mod_q;
  assign width_o   = width_q;
  assign height_o  = height_q;
  assign minterm_o = minterm_q;
  assign en_o      = en_q;
  assign start_o   = wr_ok && (cfg_idx == RG_START);

endmodule

// File: rtl/blit_addr_gen.sv
module blit_addr_gen #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              step,
  input  logic              row_end,
  input  logic [ADDR_W-1:0] modulo,
  output logic [ADDR_W-1:0] ptr
);

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_d;
  logic              ptr_en;

  always_comb begin
    ptr_en = load || step;
    if (load) begin
      ptr_d = base;
    end else if (row_end) begin
      ptr_d = ptr_q + ADDR_W'(1) + modulo;
    end else begin
      ptr_d = ptr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/blit_minterm.sv
module blit_minterm #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_c,
  input  logic [7:0]        code,
  output logic [DATA_W-1:0] result
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign result[i] = code[{src_a[i], src_b[i], src_c[i]}];
  end

endmodule

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       en,
  input  logic [CNT_W-1:0] width,
  input  logic [CNT_W-1:0] height,
  input  logic             gnt,
  output blit_state_t      state,
  output logic             row_end,
  output logic             load,
  output logic             done
);

  localparam int unsigned CW1 = CNT_W + 1;

  blit_state_t      state_q, state_d;
  logic [CNT_W-1:0] col_q, col_d;
  logic [CNT_W-1:0] row_q, row_d;
  logic             done_q, done_d;
  logic             cnt_en;
  logic             last_col, last_row;

  // a count of zero behaves as one
  assign last_col = (({1'b0, col_q} + CW1'(1)) >= {1'b0, width});
  assign last_row = (({1'b0, row_q} + CW1'(1)) >= {1'b0, height});

  always_comb begin
    state_d = state_q;
    col_d   = col_q;
    row_d   = row_q;
    done_d  = 1'b0;
    cnt_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = next_phase(ST_IDLE, en);
          col_d   = '0;
          row_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_RDA, ST_RDB, ST_RDC: begin
        if (gnt) state_d = next_phase(state_q, en);
      end
      ST_WRD: begin
        if (gnt) begin
          cnt_en = 1'b1;
          if (last_col && last_row) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = next_phase(ST_WRD, en);
            col_d   = last_col ? '0 : col_q + CNT_W'(1);
            row_d   = last_col ? row_q + CNT_W'(1) : row_q;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (cnt_en) begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  assign state   = state_q;
  assign row_end = last_col;
  assign load    = (state_q == ST_IDLE) && start;
  assign done    = done_q;

endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_idx,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata
);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [NUM_CH-1:0][ADDR_W-1:0] base;
  logic [NUM_CH-1:0][ADDR_W-1:0] modulo;
  logic [CNT_W-1:0]              width;
  logic [CNT_W-1:0]              height;
  logic [7:0]                    minterm;
  logic [2:0]                    en;
  logic                          start;
  blit_state_t                   st;
  logic                          row_end;
  logic                          load;
  logic [NUM_CH-1:0]             step;
  logic [NUM_CH-1:0][ADDR_W-1:0] ptr;

  assign busy = (st != ST_IDLE);

  blit_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .lock      (busy),
    .base_o    (base),
    .mod_o     (modulo),
    .width_o   (width),
    .height_o  (height),
    .minterm_o (minterm),
    .en_o      (en),
    .start_o   (start)
  );

  blit_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start   (start),
    .en      (en),
    .width   (width),
    .height  (height),
    .gnt     (mem_gnt),
    .state   (st),
    .row_end (row_end),
    .load    (load),
    .done    (done)
  );

  // one address walker per channel, each stepping on its own grant
  for (genvar g = 0; g < NUM_CH; g++) begin : g_walk
    assign step[g] = mem_gnt && (st == blit_state_t'(3'(g + 1)));

    blit_addr_gen #(.ADDR_W(ADDR_W)) u_walk (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .load    (load),
      .base    (base[g]),
      .step    (step[g]),
      .row_end (row_end),
      .modulo  (modulo[g]),
      .ptr     (ptr[g])
    );
  end

  // source word holding registers
  logic [DATA_W-1:0] a_q, b_q, c_q;
  logic [DATA_W-1:0] a_src, b_src, c_src;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else begin
      if (step[CH_A]) a_q <= mem_rdata;
      if (step[CH_B]) b_q <= mem_rdata;
      if (step[CH_C]) c_q <= mem_rdata;
    end
  end

  assign a_src = en[0] ? a_q : '0;
  assign b_src = en[1] ? b_q : '0;
  assign c_src = en[2] ? c_q : '0;

  blit_minterm #(.DATA_W(DATA_W)) u_logic (
    .src_a  (a_src),
    .src_b  (b_src),
    .src_c  (c_src),
    .code   (minterm),
    .result (mem_wdata)
  );

  always_comb begin
    mem_req  = busy;
    mem_we   = (st == ST_WRD);
    case (st)
      ST_RDA:  mem_addr = ptr[CH_A];
      ST_RDB:  mem_addr = ptr[CH_B];
      ST_RDC:  mem_addr = ptr[CH_C];
      ST_WRD:  mem_addr = ptr[CH_D];
      default: mem_addr = '0;
    endcase
  end

endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk
  import blit_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              cfg_we,
  input logic [3:0]        cfg_idx,
  input logic [2:0]        state,
  input logic [2:0]        en
);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_read_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |->
      ((state == 3'(ST_RDA) && en[0]) || (state == 3'(ST_RDB) && en[1]) ||
       (state == 3'(ST_RDC) && en[2])));

  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_idx == RG_START && !busy) |=> busy);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

endmodule

bind blit_engine blit_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .busy     (busy),
  .done     (done),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_gnt  (mem_gnt),
  .mem_addr (mem_addr),
  .cfg_we   (cfg_we),
  .cfg_idx  (cfg_idx),
  .state    (st),
  .en       (en)
);

// File: tb/blit_engine_tb.sv
module blit_engine_tb;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [15:0] cfg_wdata;
  logic        busy, done, mem_req, mem_we, mem_gnt;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  int errs   = 0;
  int checks = 0;
  int cyc    = 0;
  int done_cnt = 0;
  int gnt_pct  = 75;

  logic [15:0] mem   [0:4095];
  logic [15:0] model [0:4095];
  logic [16:0] log_q [$];
  logic [16:0] exp_q [$];

  blit_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .busy(busy), .done(done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[11:0]];

  always @(posedge clk) begin
    if (mem_req && mem_gnt) begin
      log_q.push_back({mem_we, mem_addr});
      if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    end
  end

  always @(negedge clk) begin
    mem_gnt <= (($urandom % 100) < gnt_pct);
    if (done) done_cnt++;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; errs++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] combine(logic [15:0] a, logic [15:0] b,
                                          logic [15:0] c, logic [7:0] mt);
    logic [15:0] d;
    for (int i = 0; i < 16; i++) d[i] = mt[{a[i], b[i], c[i]}];
    return d;
  endfunction

  task automatic cfg_write(input logic [3:0] idx, input logic [15:0] val);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_blit(input logic [15:0] bs [4], input logic [15:0] md [4],
                          input int w, input int h, input logic [7:0] mt,
                          input logic [2:0] en, input bit poke, input string tag);
    int ew, eh, nrd, nwr, tmo;
    logic [15:0] p [4];
    logic [15:0] av, bv, cv;
    bit seq_ok, mem_ok;
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 16'($urandom);
      model[i] = mem[i];
    end
    ew = (w == 0) ? 1 : w;
    eh = (h == 0) ? 1 : h;
    exp_q.delete();
    for (int k = 0; k < 4; k++) p[k] = bs[k];
    for (int r = 0; r < eh; r++) begin
      for (int c = 0; c < ew; c++) begin
        av = '0; bv = '0; cv = '0;
        if (en[0]) begin exp_q.push_back({1'b0, p[0]}); av = model[p[0][11:0]]; end
        if (en[1]) begin exp_q.push_back({1'b0, p[1]}); bv = model[p[1][11:0]]; end
        if (en[2]) begin exp_q.push_back({1'b0, p[2]}); cv = model[p[2][11:0]]; end
        exp_q.push_back({1'b1, p[3]});
        model[p[3][11:0]] = combine(av, bv, cv, mt);
        for (int k = 0; k < 4; k++)
          p[k] = (c == ew - 1) ? p[k] + 16'd1 + md[k] : p[k] + 16'd1;
      end
    end
    log_q.delete();
    done_cnt = 0;
    for (int k = 0; k < 4; k++) begin
      cfg_write(4'(k), bs[k]);
      cfg_write(4'(4 + k), md[k]);
    end
    cfg_write(4'd8, 16'(w));
    cfg_write(4'd9, 16'(h));
    cfg_write(4'd10, {8'h00, mt});
    cfg_write(4'd11, {13'd0, en});
    cfg_write(4'd12, 16'd1);
    check(busy === 1'b1, "R6", {tag, " busy one cycle after start"}, busy, 1);
    if (poke) begin
      @(negedge clk);
      check(busy === 1'b1, "R6", {tag, " still busy before poke"}, busy, 1);
      cfg_write(4'd12, 16'd1);
      cfg_write(4'd10, {8'h00, ~mt});
      cfg_write(4'd3, bs[3] + 16'd7);
      cfg_write(4'd11, 16'd0);
    end
    tmo = 0;
    while (done_cnt == 0 && tmo < 20000) begin
      @(negedge clk);
      tmo++;
    end
    @(negedge clk);
    @(negedge clk);
    check(done_cnt == 1, "R7", {tag, " done pulse count"}, done_cnt, 1);
    check(busy === 1'b0 && mem_req === 1'b0, "R7", {tag, " idle after done"},
          {busy, mem_req}, 0);
    seq_ok = (log_q.size() == exp_q.size());
    if (seq_ok)
      for (int i = 0; i < exp_q.size(); i++)
        if (log_q[i] !== exp_q[i]) seq_ok = 1'b0;
    check(seq_ok, "R3/R4", {tag, " access order and addresses (size)"},
          log_q.size(), exp_q.size());
    nrd = 0; nwr = 0;
    foreach (log_q[i]) if (log_q[i][16]) nwr++; else nrd++;
    check(nwr == ew * eh, "R5", {tag, " D write count"}, nwr, ew * eh);
    check(nrd == $countones(en) * ew * eh, "R2", {tag, " source read count"},
          nrd, $countones(en) * ew * eh);
    mem_ok = 1'b1;
    for (int i = 0; i < 4096; i++) if (mem[i] !== model[i]) mem_ok = 1'b0;
    check(mem_ok, "R1", {tag, " memory image after blit"}, mem_ok, 1);
  endtask

  initial begin
    logic [15:0] bs [4];
    logic [15:0] md [4];
    void'($urandom(32'h5EED_B17));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0; mem_gnt = 1'b0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R8",
          "reset outputs", {busy, done, mem_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && mem_req === 1'b0, "R8", "idle after reset release",
          {busy, mem_req}, 0);

    // directed: copy with only A enabled
    bs = '{16'h0010, 16'h0300, 16'h0600, 16'h0900};
    md = '{16'd2, 16'd0, 16'd0, 16'd3};
    run_blit(bs, md, 4, 3, 8'hF0, 3'b001, 1'b0, "R9 copy");
    // directed: masked overlay, destination merged
    bs = '{16'h0020, 16'h0320, 16'h0920, 16'h0920};
    md = '{16'd1, 16'd1, 16'd4, 16'd4};
    run_blit(bs, md, 5, 4, 8'hCA, 3'b111, 1'b0, "R9 cookie");
    // directed: XOR of A and destination, B disabled
    bs = '{16'h0040, 16'h0340, 16'h0940, 16'h0940};
    md = '{16'd0, 16'd0, 16'd2, 16'd2};
    run_blit(bs, md, 3, 5, 8'h5A, 3'b101, 1'b0, "R9 xor");
    // zero size acts as one word, no sources
    bs = '{16'h0050, 16'h0350, 16'h0650, 16'h0950};
    md = '{16'd0, 16'd0, 16'd0, 16'd0};
    run_blit(bs, md, 0, 0, 8'hFF, 3'b000, 1'b0, "R5 zero-size");
    // negative modulo on D (two's complement wrap of address)
    bs = '{16'h0060, 16'h0360, 16'h0660, 16'h0A60};
    md = '{16'd0, 16'd3, 16'd0, 16'hFFFE};
    run_blit(bs, md, 4, 4, 8'hC0, 3'b011, 1'b0, "R4 negative modulo");
    // writes during busy must be ignored
    gnt_pct = 40;
    bs = '{16'h0070, 16'h0370, 16'h0970, 16'h0970};
    md = '{16'd1, 16'd2, 16'd0, 16'd0};
    run_blit(bs, md, 6, 5, 8'hE2, 3'b111, 1'b1, "R6 poke while busy");
    // always granted
    gnt_pct = 100;
    bs = '{16'h0080, 16'h0380, 16'h0680, 16'h0980};
    md = '{16'd0, 16'd0, 16'd0, 16'd0};
    run_blit(bs, md, 7, 2, 8'h96, 3'b111, 1'b0, "R3 full grant");

    // constrained random
    for (int t = 0; t < 20; t++) begin
      gnt_pct = 30 + int'($urandom % 71);
      bs[0] = 16'($urandom % 64);
      bs[1] = 16'h0300 + 16'($urandom % 64);
      bs[2] = 16'h0600 + 16'($urandom % 64);
      bs[3] = ($urandom % 2) ? bs[2] + 16'h0300 : 16'h0C00 + 16'($urandom % 64);
      if (bs[3] >= 16'h0900 && bs[3] < 16'h0C00) bs[2] = bs[3];
      for (int k = 0; k < 4; k++) md[k] = 16'($urandom % 7);
      md[2] = (bs[2] == bs[3]) ? md[3] : md[2];
      run_blit(bs, md, int'($urandom % 7), int'($urandom % 6), 8'($urandom),
               3'($urandom), 1'b0, "R1 random");
    end

    summary();
    $finish;
  end

endmodule